// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a cache and main memory and holds writes that are waiting to reach memory. Single-word stores and whole dirty lines evicted by the cache both enter the same small queue. Stores to words of one aligned block share one entry, which carries a per-word mask. Entries leave one at a time, oldest first, as block-sized masked memory writes. They drain only while no read miss is waiting.

A read miss presents a block address on the read port. If no queued entry holds that block, the read goes out on the memory port at once, ahead of the queued writes. If an entry holds that block, the read is stalled and the queue keeps draining in order until that entry has left. Only then is the read issued, so it always sees the newest data. A dirty line evicted on a read miss can be enqueued in the same cycle the read is issued. Read data returns to the cache outside this block.

Top module: `wbuf_top`

## Requirements
- R1: After reset the buffer is empty. With all requests low, mem_valid, wr_stall, ev_stall and rd_grant are 0.
- R2: A word write to word address A enters the buffer and later leaves as one memory write. That write has mem_addr = A with its low log2(WORDS) bits removed, and its data in word slot w = A mod WORDS, which is mem_wdata bits [w*DATA_W +: DATA_W]. mem_wmask has only bit w set.
- R3: Word writes to one block whose entry is not being drained merge into that entry. They produce a single memory write whose mask is the OR of their word bits, and a word written twice carries the later data.
- R4: When every entry is in use, a write that cannot merge is refused with wr_stall = 1 and never reaches memory. A write that can merge into a non-draining entry is still accepted.
- R5: Entries leave in allocation order, one entry per accepted memory write.
- R6: A read whose block matches no queued entry is issued before any queued entry that is not already held on the port. rd_grant is 1 in the cycle the memory accepts it (mem_valid = 1, mem_write = 0, mem_ready = 1).
- R7: A read whose block matches a queued entry is not granted while any matching entry remains. The entries ahead of and including the match are written first, and then the read is granted.
- R8: An evicted line enters as one entry with all mask bits set and its line data unchanged. When an eviction and a word write arrive together, the eviction is taken and the write is stalled.
- R9: A word write to the block of the entry currently presented as a memory write takes a new entry instead of merging. That block then leaves as two memory writes.
- R10: A memory write that has been presented but not yet accepted stays on the port with its address, data and mask unchanged until mem_ready. A read arriving meanwhile waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Word write request |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_stall | output | 1 | Word write not taken this cycle |
| ev_valid | input | 1 | Evicted dirty line request |
| ev_blk | input | ADDR_W-log2(WORDS) | Block address of the evicted line |
| ev_line | input | WORDS*DATA_W | Evicted line data |
| ev_stall | output | 1 | Evicted line not taken this cycle |
| rd_valid | input | 1 | Read miss request, held until granted |
| rd_blk | input | ADDR_W-log2(WORDS) | Block address of the read miss |
| rd_grant | output | 1 | Read accepted by memory this cycle |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = masked block write, 0 = block read |
| mem_addr | output | ADDR_W-log2(WORDS) | Memory block address |
| mem_wdata | output | WORDS*DATA_W | Block write data |
| mem_wmask | output | WORDS | Per-word write enable |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
The checker watches every cycle for four things. A waiting memory write must stay stable and must not be pre-empted. A grant may only appear with a memory read that is being accepted, and only while no queued entry holds the read's block. A simultaneous word write must stall behind an eviction. A presented write must carry a non-empty mask. The bench scenarios are needed to show what single cycles cannot: merged data content, last-write-wins per word, FIFO drain order, refusal of a write when full, and the exact sequence in which a conflicting read overtakes or waits for queued writes.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    // Owner of the memory port in a given cycle
    typedef enum logic [1:0] {
        SEL_IDLE  = 2'd0,
        SEL_READ  = 2'd1,
        SEL_DRAIN = 2'd2
    } port_sel_e;

    // Pointer width for a queue of n slots (at least one bit)
    function automatic int ptr_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbuf_hazard.sv
module wbuf_hazard #(
    parameter int BLK_W = 10,
    parameter int DEPTH = 4
) (
    input  logic [BLK_W-1:0]       rd_blk,
    input  logic [DEPTH-1:0]       ent_valid,
    input  logic [DEPTH*BLK_W-1:0] ent_blk,
    output logic                   conflict
);

    logic [DEPTH-1:0] hit;

    // One block-address comparator per entry
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit[i] = ent_valid[i] && (ent_blk[i*BLK_W +: BLK_W] == rd_blk);
    end

    assign conflict = |hit;

endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb
    import wbuf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      rd_valid,
    input  logic      conflict,
    input  logic      head_valid,
    input  logic      mem_ready,
    output port_sel_e sel,
    output logic      deq,
    output logic      rd_grant
);

    logic hold_q;

    // A write already on the port keeps it; otherwise reads win
    always_comb begin
        if (hold_q)                     sel = SEL_DRAIN;
        else if (rd_valid && !conflict) sel = SEL_READ;
        else if (head_valid)            sel = SEL_DRAIN;
        else                            sel = SEL_IDLE;
    end

    assign deq      = (sel == SEL_DRAIN) && mem_ready;
    assign rd_grant = (sel == SEL_READ)  && mem_ready;

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= (sel == SEL_DRAIN) && !mem_ready;
    end

endmodule

// File: rtl/wbuf_store.sv
module wbuf_store #(
    parameter int BLK_W  = 10,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     enq_valid,
    input  logic [BLK_W-1:0]         enq_blk,
    input  logic [WORDS*DATA_W-1:0]  enq_line,
    input  logic [WORDS-1:0]         enq_mask,
    input  logic                     head_busy,
    input  logic                     deq,
    output logic                     enq_ok,
    output logic [DEPTH-1:0]         ent_valid,
    output logic [DEPTH*BLK_W-1:0]   ent_blk,
    output logic                     head_valid,
    output logic [BLK_W-1:0]         head_blk,
    output logic [WORDS*DATA_W-1:0]  head_line,
    output logic [WORDS-1:0]         head_mask
);

    localparam int PTR_W  = wbuf_pkg::ptr_width(DEPTH);
    localparam int LINE_W = WORDS * DATA_W;

    logic [DEPTH-1:0]  vld;
    logic [BLK_W-1:0]  blk_q  [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];
    logic [WORDS-1:0]  mask_q [DEPTH];
    logic [PTR_W-1:0]  head_q, tail_q;

    logic [DEPTH-1:0]  can_merge;
    logic              merge_hit;
    logic [PTR_W-1:0]  merge_idx;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Merge candidates: same block, excluding the entry on the port
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        assign can_merge[i] = vld[i] && (blk_q[i] == enq_blk)
                              && !(head_busy && (head_q == PTR_W'(i)));
        assign ent_blk[i*BLK_W +: BLK_W] = blk_q[i];
    end

    always_comb begin
        merge_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (can_merge[i]) merge_idx = PTR_W'(i);
        end
    end

    assign merge_hit  = |can_merge;
    assign enq_ok     = enq_valid && (merge_hit || !vld[tail_q]);
    assign ent_valid  = vld;
    assign head_valid = vld[head_q];
    assign head_blk   = blk_q[head_q];
    assign head_line  = line_q[head_q];
    assign head_mask  = mask_q[head_q];

    // Occupancy and pointers
    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= '0;
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (deq) begin
                vld[head_q] <= 1'b0;
                head_q      <= bump(head_q);
            end
            if (enq_ok && !merge_hit) begin
                vld[tail_q] <= 1'b1;
                tail_q      <= bump(tail_q);
            end
        end
    end

    // Entry payload
    always_ff @(posedge clk) begin
        if (enq_ok) begin
            if (merge_hit) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (enq_mask[w])
                        line_q[merge_idx][w*DATA_W +: DATA_W] <= enq_line[w*DATA_W +: DATA_W];
                end
                mask_q[merge_idx] <= mask_q[merge_idx] | enq_mask;
            end else begin
                blk_q[tail_q]  <= enq_blk;
                line_q[tail_q] <= enq_line;
                mask_q[tail_q] <= enq_mask;
            end
        end
    end

endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
    import wbuf_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int WORDS  = 4,
    parameter int DEPTH  = 4,
    localparam int OFS_W  = $clog2(WORDS),
    localparam int BLK_W  = ADDR_W - OFS_W,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_stall,
    input  logic              ev_valid,
    input  logic [BLK_W-1:0]  ev_blk,
    input  logic [LINE_W-1:0] ev_line,
    output logic              ev_stall,
    input  logic              rd_valid,
    input  logic [BLK_W-1:0]  rd_blk,
    output logic              rd_grant,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [BLK_W-1:0]  mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [WORDS-1:0]  mem_wmask,
    input  logic              mem_ready
);

    logic                   enq_valid, enq_ok;
    logic [BLK_W-1:0]       enq_blk;
    logic [LINE_W-1:0]      enq_line;
    logic [WORDS-1:0]       enq_mask;
    logic [DEPTH-1:0]       ent_valid;
    logic [DEPTH*BLK_W-1:0] ent_blk;
    logic                   head_valid;
    logic [BLK_W-1:0]       head_blk;
    logic [LINE_W-1:0]      head_line;
    logic [WORDS-1:0]       head_mask;
    logic                   conflict, deq;
    port_sel_e              sel;

    // Evictions take the enqueue path ahead of word writes
    always_comb begin
        if (ev_valid) begin
            enq_blk  = ev_blk;
            enq_line = ev_line;
            enq_mask = '1;
        end else begin
            enq_blk  = wr_addr[ADDR_W-1:OFS_W];
            enq_line = {WORDS{wr_data}};
            enq_mask = WORDS'(1) << wr_addr[OFS_W-1:0];
        end
    end

    assign enq_valid = ev_valid || wr_valid;
    assign ev_stall  = ev_valid && !enq_ok;
    assign wr_stall  = wr_valid && (ev_valid || !enq_ok);

    wbuf_store #(
        .BLK_W (BLK_W),
        .DATA_W(DATA_W),
        .WORDS (WORDS),
        .DEPTH (DEPTH)
    ) i_store (
        .clk       (clk),
        .rst       (rst),
        .enq_valid (enq_valid),
        .enq_blk   (enq_blk),
        .enq_line  (enq_line),
        .enq_mask  (enq_mask),
        .head_busy (sel == SEL_DRAIN),
        .deq       (deq),
        .enq_ok    (enq_ok),
        .ent_valid (ent_valid),
        .ent_blk   (ent_blk),
        .head_valid(head_valid),
        .head_blk  (head_blk),
        .head_line (head_line),
        .head_mask (head_mask)
    );

    wbuf_hazard #(
        .BLK_W(BLK_W),
        .DEPTH(DEPTH)
    ) i_hazard (
        .rd_blk   (rd_blk),
        .ent_valid(ent_valid),
        .ent_blk  (ent_blk),
        .conflict (conflict)
    );

    wbuf_arb i_arb (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .conflict  (conflict),
        .head_valid(head_valid),
        .mem_ready (mem_ready),
        .sel       (sel),
        .deq       (deq),
        .rd_grant  (rd_grant)
    );

    assign mem_valid = (sel != SEL_IDLE);
    assign mem_write = (sel == SEL_DRAIN);
    assign mem_addr  = mem_write ? head_blk : rd_blk;
    assign mem_wdata = mem_write ? head_line : '0;
    assign mem_wmask = mem_write ? head_mask : '0;

endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
    parameter int BLK_W  = 10,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_valid,
    input logic                    wr_stall,
    input logic                    ev_valid,
    input logic                    rd_valid,
    input logic [BLK_W-1:0]        rd_blk,
    input logic                    rd_grant,
    input logic                    mem_valid,
    input logic                    mem_write,
    input logic                    mem_ready,
    input logic [BLK_W-1:0]        mem_addr,
    input logic [WORDS*DATA_W-1:0] mem_wdata,
    input logic [WORDS-1:0]        mem_wmask,
    input logic [DEPTH-1:0]        ent_valid,
    input logic [DEPTH*BLK_W-1:0]  ent_blk
);

    logic pend_match;

    always_comb begin
        pend_match = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_valid[i] && ent_blk[i*BLK_W +: BLK_W] == rd_blk) pend_match = 1'b1;
        end
    end

    // R10
    write_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write && !mem_ready) |=>
        (mem_valid && mem_write && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_wmask)));

    // R6
    grant_port_chk: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> (rd_valid && mem_valid && !mem_write && mem_ready));

    // R7
    raw_block_chk: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> !pend_match);

    // R8
    evict_first_chk: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && wr_valid) |-> wr_stall);

    // R2
    mask_live_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_write) |-> (mem_wmask != '0));

    // R1
    empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (ent_valid == '0) |-> !(mem_valid && mem_write));

endmodule

bind wbuf_top wbuf_chk #(
    .BLK_W (BLK_W),
    .WORDS (WORDS),
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_valid (wr_valid),
    .wr_stall (wr_stall),
    .ev_valid (ev_valid),
    .rd_valid (rd_valid),
    .rd_blk   (rd_blk),
    .rd_grant (rd_grant),
    .mem_valid(mem_valid),
    .mem_write(mem_write),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask),
    .ent_valid(ent_valid),
    .ent_blk  (ent_blk)
);

// File: tb/test_wbuf_top.sv
module test_wbuf_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_valid = 1'b0;
    logic [11:0]  wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic         wr_stall;
    logic         ev_valid = 1'b0;
    logic [9:0]   ev_blk = '0;
    logic [127:0] ev_line = '0;
    logic         ev_stall;
    logic         rd_valid = 1'b0;
    logic [9:0]   rd_blk = '0;
    logic         rd_grant;
    logic         mem_valid, mem_write;
    logic [9:0]   mem_addr;
    logic [127:0] mem_wdata;
    logic [3:0]   mem_wmask;
    logic         mem_ready = 1'b0;

    always #2 clk = ~clk;

    wbuf_top i_wbuf_top (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_stall(wr_stall),
        .ev_valid(ev_valid), .ev_blk(ev_blk), .ev_line(ev_line), .ev_stall(ev_stall),
        .rd_valid(rd_valid), .rd_blk(rd_blk), .rd_grant(rd_grant),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_ready(mem_ready)
    );

    int errors = 0;
    int checks = 0;

    // Log of accepted memory transactions
    logic         lg_w [64];
    logic [9:0]   lg_a [64];
    logic [127:0] lg_d [64];
    logic [3:0]   lg_m [64];
    int           lg_n = 0;
    logic         s_wst, s_est, s_gnt, s_mv, s_mw;

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] data;
        logic [9:0]  blk;
        logic [3:0]  mask;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{12'h000, 32'hA0A0_0001, 10'h000, 4'b0001},
        '{12'h001, 32'hB1B1_0002, 10'h000, 4'b0010},
        '{12'h0A6, 32'hC2C2_0003, 10'h029, 4'b0100},
        '{12'hFFF, 32'hD3D3_0004, 10'h3FF, 4'b1000},
        '{12'h7F4, 32'hE4E4_0005, 10'h1FD, 4'b0001},
        '{12'h123, 32'hF5F5_0006, 10'h048, 4'b1000}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample 1 ns before the rising edge, then move to the next falling edge
    task automatic tick();
        #1;
        s_wst = wr_stall; s_est = ev_stall; s_gnt = rd_grant;
        s_mv = mem_valid; s_mw = mem_write;
        if (mem_valid && mem_ready && lg_n < 64) begin
            lg_w[lg_n] = mem_write; lg_a[lg_n] = mem_addr;
            lg_d[lg_n] = mem_wdata; lg_m[lg_n] = mem_wmask;
            lg_n++;
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_valid = 1'b0;
    endtask

    task automatic chk_wr(input int idx, input string req, input logic [9:0] a, input logic [3:0] m);
        chk(lg_w[idx] === 1'b1, req, 128'(lg_w[idx]), 128'd1);
        chk(lg_a[idx] === a, req, 128'(lg_a[idx]), 128'(a));
        chk(lg_m[idx] === m, req, 128'(lg_m[idx]), 128'(m));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: quiet after reset
        tick();
        chk(!s_mv, "R1 mem_valid", 128'(s_mv), 128'd0);
        chk(!s_wst && !s_est, "R1 stalls", 128'({s_wst, s_est}), 128'd0);
        chk(!s_gnt, "R1 rd_grant", 128'(s_gnt), 128'd0);

        // R2: table of single word writes
        mem_ready = 1'b1;
        for (int v = 0; v < 6; v++) begin
            wr(VECS[v].addr, VECS[v].data);
            n0 = lg_n;
            tick();
            chk(lg_n == n0 + 1, "R2 one write", 128'(lg_n - n0), 128'd1);
            chk_wr(n0, "R2 write", VECS[v].blk, VECS[v].mask);
            chk(lg_d[n0][VECS[v].addr[1:0]*32 +: 32] == VECS[v].data, "R2 data slot",
                128'(lg_d[n0][VECS[v].addr[1:0]*32 +: 32]), 128'(VECS[v].data));
        end

        // R3/R5: merge into a non-draining entry
        mem_ready = 1'b0;
        n0 = lg_n;
        wr(12'h040, 32'h0000_0AAA);
        wr(12'h050, 32'h0000_0011);
        wr(12'h052, 32'h0000_0022);
        wr(12'h050, 32'h0000_0033);
        chk(!s_wst, "R3 merge accepted", 128'(s_wst), 128'd0);
        mem_ready = 1'b1;
        repeat (4) tick();
        chk(lg_n == n0 + 2, "R3 merged count", 128'(lg_n - n0), 128'd2);
        chk_wr(n0, "R5 first", 10'h010, 4'b0001);
        chk_wr(n0 + 1, "R3 merged", 10'h014, 4'b0101);
        chk(lg_d[n0 + 1][31:0] == 32'h33, "R3 latest word", 128'(lg_d[n0 + 1][31:0]), 128'h33);
        chk(lg_d[n0 + 1][95:64] == 32'h22, "R3 second word", 128'(lg_d[n0 + 1][95:64]), 128'h22);

        // R9: no merge into the entry on the port
        mem_ready = 1'b0;
        n0 = lg_n;
        wr(12'h0C5, 32'h55);
        wr(12'h0C7, 32'h77);
        mem_ready = 1'b1;
        repeat (3) tick();
        chk(lg_n == n0 + 2, "R9 two writes", 128'(lg_n - n0), 128'd2);
        chk_wr(n0, "R9 old entry", 10'h031, 4'b0010);
        chk_wr(n0 + 1, "R9 new entry", 10'h031, 4'b1000);

        // R4/R5: full buffer
        mem_ready = 1'b0;
        n0 = lg_n;
        wr(12'h400, 32'hD0);
        wr(12'h404, 32'hD1);
        wr(12'h408, 32'hD2);
        wr(12'h40C, 32'hD3);
        chk(!s_wst, "R4 fourth accepted", 128'(s_wst), 128'd0);
        wr(12'h500, 32'hEE);
        chk(s_wst, "R4 full refuses", 128'(s_wst), 128'd1);
        wr(12'h409, 32'hE1);
        chk(!s_wst, "R4 merge when full", 128'(s_wst), 128'd0);
        wr(12'h401, 32'hE2);
        chk(s_wst, "R4 head busy refuses", 128'(s_wst), 128'd1);
        mem_ready = 1'b1;
        repeat (6) tick();
        chk(lg_n == n0 + 4, "R4 count", 128'(lg_n - n0), 128'd4);
        chk_wr(n0, "R5 order 0", 10'h100, 4'b0001);
        chk_wr(n0 + 1, "R5 order 1", 10'h101, 4'b0001);
        chk_wr(n0 + 2, "R5 order 2", 10'h102, 4'b0011);
        chk_wr(n0 + 3, "R5 order 3", 10'h103, 4'b0001);

        // R6/R8: read bypass and eviction
        n0 = lg_n;
        wr(12'h600, 32'h61);
        wr_valid = 1'b1; wr_addr = 12'h604; wr_data = 32'h62;
        rd_valid = 1'b1; rd_blk = 10'h2AA;
        tick();
        chk(s_gnt && !s_mw, "R6 read first", 128'({s_gnt, s_mw}), 128'b10);
        wr_valid = 1'b1; wr_addr = 12'h700; wr_data = 32'h70;
        ev_valid = 1'b1; ev_blk = 10'h0EE;
        ev_line = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
        rd_blk = 10'h2AB;
        tick();
        chk(s_gnt, "R6 read with eviction", 128'(s_gnt), 128'd1);
        chk(s_wst && !s_est, "R8 eviction wins", 128'({s_wst, s_est}), 128'b10);
        wr_valid = 1'b0; ev_valid = 1'b0; rd_valid = 1'b0;
        repeat (5) tick();
        chk(lg_n == n0 + 5, "R8 count", 128'(lg_n - n0), 128'd5);
        chk(!lg_w[n0] && lg_a[n0] == 10'h2AA, "R6 log read", 128'(lg_a[n0]), 128'h2AA);
        chk(!lg_w[n0 + 1] && lg_a[n0 + 1] == 10'h2AB, "R6 log read 2", 128'(lg_a[n0 + 1]), 128'h2AB);
        chk_wr(n0 + 2, "R6 held write", 10'h180, 4'b0001);
        chk_wr(n0 + 3, "R6 held write 2", 10'h181, 4'b0001);
        chk_wr(n0 + 4, "R8 line", 10'h0EE, 4'b1111);
        chk(lg_d[n0 + 4] == 128'h4444_4444_3333_3333_2222_2222_1111_1111, "R8 line data",
            lg_d[n0 + 4], 128'h4444_4444_3333_3333_2222_2222_1111_1111);

        // R10/R7: held write, then conflicting read
        mem_ready = 1'b0;
        n0 = lg_n;
        wr(12'h800, 32'h80);
        wr(12'h810, 32'h81);
        wr(12'h820, 32'h82);
        rd_valid = 1'b1; rd_blk = 10'h3FF;
        tick();
        chk(!s_gnt && s_mw, "R10 write keeps port", 128'({s_gnt, s_mw}), 128'b01);
        rd_blk = 10'h204;
        tick();
        chk(!s_gnt, "R7 conflict stalls", 128'(s_gnt), 128'd0);
        mem_ready = 1'b1;
        for (int k = 0; k < 10; k++) begin
            tick();
            if (s_gnt) break;
        end
        rd_valid = 1'b0;
        repeat (3) tick();
        chk(lg_n == n0 + 4, "R7 count", 128'(lg_n - n0), 128'd4);
        chk_wr(n0, "R7 older drains", 10'h200, 4'b0001);
        chk_wr(n0 + 1, "R7 match drains", 10'h204, 4'b0001);
        chk(!lg_w[n0 + 2] && lg_a[n0 + 2] == 10'h204, "R7 read after match",
            128'({lg_w[n0 + 2], lg_a[n0 + 2]}), 128'h204);
        chk_wr(n0 + 3, "R7 younger after read", 10'h208, 4'b0001);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule